// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind a serial-bus slave front end in a nonvolatile memory and carries out byte and page writes into the storage array. The front end hands it a word address, then a stream of data bytes, and finally a start or stop event. The block gathers the bytes into a one-page holding buffer. The upper bits of the word address pick the page row. The low bits form an in-page pointer that steps after each byte and wraps inside the page.

A stop that closes a transaction with at least one buffered byte starts a timed write period of `WRITE_CYCLES` clock cycles, unless the write-protect input is high. During that period the block holds `busy` high so that the front end withholds its acknowledges. In the first `PAGE_BYTES` cycles of the period it copies each buffered location into the array through a plain RAM write port. A start or repeated start that arrives before the stop throws the buffer away. The block ignores every strobe while `busy` is high.

Top module: `pgw_ctrl`

## Requirements
- R1: Out of reset, `busy` and `mem_we` are low and the holding buffer is empty.
- R2: An `addr_ld` strobe loads the word address. Bits [ADDR_W-1:6] select the page row and bits [5:0] set the in-page pointer (PAGE_BYTES = 64).
- R3: Each `byte_vld` strobe stores `byte_data` at the current pointer and marks that location as written. The pointer then advances by one and the row does not change.
- R4: After offset 63 the pointer wraps to offset 0 of the same row. A later byte for an offset that already holds data replaces the earlier value.
- R5: Nothing is written to the array before the stop that ends the transaction.
- R6: After a committing stop, each marked location is written exactly once. Locations go out in ascending offset order, and offset i is written in the i-th cycle of the busy period (counting from 0). `mem_addr` is {row, offset}. Unmarked locations are not written.
- R7: `busy` rises in the cycle after the committing stop and stays high for exactly WRITE_CYCLES cycles.
- R8: While `busy` is high, the block ignores address, data, start and stop strobes.
- R9: A stop that arrives while `wp_in` is high writes nothing and leaves `busy` low. It also discards the buffered bytes.
- R10: A start strobe before the stop discards the buffered bytes, so no write cycle follows for them.
- R11: A stop with no buffered data bytes (for example, only a word address was sent) leaves `busy` low.
- R12: After a write period ends the buffer is empty, so the next transaction commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_seen | input | 1 | Start or repeated start detected by the front end |
| addr_ld | input | 1 | Word address strobe |
| word_addr | input | ADDR_W | Word address, valid with `addr_ld` |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data byte, valid with `byte_vld` |
| stop_seen | input | 1 | Stop detected by the front end |
| wp_in | input | 1 | Write protect; high blocks every array write |
| busy | output | 1 | Timed write period in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The bench targets the pointer crossing offset 63. A design that carries into the row bits there would put the wrapped bytes on the next page. The bench also sends 66 bytes in one transaction: a design that appends instead of overwriting would write stale values, or more than 64 writes, at offsets 0 and 1. It issues stops under write protect, stops with no data, and starts that cut off a transaction. A design that keeps stale valid marks would, on a later lone stop, raise `busy` or write old bytes. Strobes sent during the busy period must leave no trace in the buffer afterwards, and the length of each busy run is measured against WRITE_CYCLES.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   function automatic bit pgw_is_pow2(input int val);
      return (val > 0) && ((val & (val - 1)) == 0);
   endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 64,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int ROW_W     = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld_addr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_byte,
   input  logic [DATA_W-1:0] din,
   input  logic [OFS_W-1:0]  rd_idx,
   output logic [ROW_W-1:0]  row,
   output logic              rd_vld,
   output logic [DATA_W-1:0] rd_data,
   output logic              any_vld
);

   localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(PAGE_BYTES - 1);

   logic [ROW_W-1:0]      row_q;
   logic [OFS_W-1:0]      ofs_q;
   logic [PAGE_BYTES-1:0] mask_q;
   logic [DATA_W-1:0]     data_q [PAGE_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         ofs_q <= '0;
      end else if (ld_addr) begin
         row_q <= addr[ADDR_W-1:OFS_W];
         ofs_q <= addr[OFS_W-1:0];
      end else if (wr_byte) begin
         ofs_q <= ofs_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask_q[g] <= 1'b0;
               data_q[g] <= '0;
            end else if (clr) begin
               mask_q[g] <= 1'b0;
            end else if (wr_byte && ofs_q == OFS_W'(g)) begin
               mask_q[g] <= 1'b1;
               data_q[g] <= din;
            end
         end
      end
   endgenerate

   assign row     = row_q;
   assign rd_vld  = mask_q[rd_idx];
   assign rd_data = data_q[rd_idx];
   assign any_vld = |mask_q;

   // R4
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte && !ld_addr && ofs_q == OFS_LAST) |=> (ofs_q == '0));

   // R3
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte && !ld_addr) |=> $stable(row_q));

   // R10
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !any_vld);

endmodule

// File: rtl/pgw_wr_timer.sv
module pgw_wr_timer #(
   parameter int WRITE_CYCLES = 250000,
   localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (go && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == CNT_LAST) busy_q <= 1'b0;
         else                   cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign cnt  = cnt_q;
   assign done = busy_q && (cnt_q == CNT_LAST);

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != CNT_LAST) |=> busy_q);

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == CNT_LAST) |=> !busy_q);

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
   parameter int ADDR_W       = 15,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 64,
   parameter int WRITE_CYCLES = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_seen,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] word_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_seen,
   input  logic              wp_in,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);

   import pgw_pkg::*;

   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int ROW_W = ADDR_W - OFS_W;
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
   localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

   generate
      if (!pgw_is_pow2(PAGE_BYTES) || PAGE_BYTES < 2)
         $error("PAGE_BYTES must be a power of two of at least 2");
      if (ADDR_W <= OFS_W)
         $error("ADDR_W must exceed the in-page offset width");
      if (WRITE_CYCLES < PAGE_BYTES)
         $error("WRITE_CYCLES must cover one scan of the page");
   endgenerate

   logic             idle;
   logic             commit;
   logic             buf_clr;
   logic             do_ld;
   logic             do_wr;
   logic             t_busy;
   logic             t_done;
   logic [CNT_W-1:0] t_cnt;
   logic [OFS_W-1:0] scan_idx;
   logic [ROW_W-1:0] row;
   logic             slot_vld;
   logic [DATA_W-1:0] slot_data;
   logic             buf_any;

   assign idle    = !t_busy;
   assign commit  = idle && stop_seen && !start_seen && buf_any && !wp_in;
   assign buf_clr = (idle && start_seen)
                  || (idle && stop_seen && !commit)
                  || t_done;
   assign do_ld   = idle && addr_ld  && !start_seen && !stop_seen;
   assign do_wr   = idle && byte_vld && !start_seen && !stop_seen;

   pgw_page_buf #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (buf_clr),
      .ld_addr (do_ld),
      .addr    (word_addr),
      .wr_byte (do_wr),
      .din     (byte_data),
      .rd_idx  (scan_idx),
      .row     (row),
      .rd_vld  (slot_vld),
      .rd_data (slot_data),
      .any_vld (buf_any)
   );

   pgw_wr_timer #(
      .WRITE_CYCLES (WRITE_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (commit),
      .busy  (t_busy),
      .done  (t_done),
      .cnt   (t_cnt)
   );

   assign scan_idx  = t_cnt[OFS_W-1:0];
   assign busy      = t_busy;
   assign mem_we    = t_busy && (t_cnt < PAGE_CNT) && slot_vld;
   assign mem_addr  = {row, scan_idx};
   assign mem_wdata = slot_data;

   // R5
   rise_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_seen));

   // R9
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && stop_seen && wp_in) |=> !busy);

   // R11
   empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && stop_seen && !buf_any) |=> !busy);

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_busy && !t_done) |=> $stable(row));

endmodule

// File: tb/pgw_ctrl_bench.sv
module pgw_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int WC = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_seen = 1'b0;
   logic          addr_ld = 1'b0;
   logic [AW-1:0] word_addr = '0;
   logic          byte_vld = 1'b0;
   logic [7:0]    byte_data = '0;
   logic          stop_seen = 1'b0;
   logic          wp_in = 1'b0;
   logic          busy;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;

   int checks = 0;
   int errors = 0;
   int busy_run = 0;
   logic [AW-1:0] qa[$];
   logic [7:0]    qd[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pgw_ctrl #(
      .ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(64), .WRITE_CYCLES(WC)
   ) u_pgw_ctrl (
      .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .addr_ld(addr_ld),
      .word_addr(word_addr), .byte_vld(byte_vld), .byte_data(byte_data),
      .stop_seen(stop_seen), .wp_in(wp_in), .busy(busy), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: array writes against the scoreboard, busy run length (R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (qa.size() == 0) begin
               chk(1'b0, "R5 unexpected write", int'(mem_addr), 0);
            end else begin
               logic [AW-1:0] ea;
               logic [7:0] ed;
               ea = qa.pop_front();
               ed = qd.pop_front();
               chk(mem_addr == ea, "R6 address", int'(mem_addr), int'(ea));
               chk(mem_wdata == ed, "R6 data", int'(mem_wdata), int'(ed));
            end
         end
         if (busy) busy_run++;
         else if (busy_run != 0) begin
            chk(busy_run == WC, "R7 busy length", busy_run, WC);
            busy_run = 0;
         end
      end
   end

   task automatic expect_wr(input logic [AW-1:0] a, input logic [7:0] d);
      qa.push_back(a);
      qd.push_back(d);
   endtask

   task automatic t_addr(input logic [AW-1:0] a);
      @(negedge clk); addr_ld = 1'b1; word_addr = a;
      @(negedge clk); addr_ld = 1'b0;
   endtask

   task automatic t_byte(input logic [7:0] d);
      @(negedge clk); byte_vld = 1'b1; byte_data = d;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic t_stop();
      @(negedge clk); stop_seen = 1'b1;
      @(negedge clk); stop_seen = 1'b0;
   endtask

   task automatic t_start();
      @(negedge clk); start_seen = 1'b1;
      @(negedge clk); start_seen = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      repeat (WC + 4) @(negedge clk);
      chk(qa.size() == 0, tag, qa.size(), 0);
      chk(busy == 1'b0, tag, int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1: empty buffer, a stop alone starts nothing
      t_stop();
      chk(busy == 1'b0, "R1 empty buffer", int'(busy), 0);

      // R2 R3 R7: single byte write
      t_addr(15'h1234);
      t_byte(8'hA5);
      expect_wr(15'h1234, 8'hA5);
      t_stop();
      chk(busy == 1'b1, "R7 busy rises", int'(busy), 1);
      wait_idle("R6 single byte");

      // R3 R5 R12: short page write, only new bytes commit
      t_addr(15'h0105);
      for (int i = 0; i < 3; i++) t_byte(8'h10 + 8'(i));
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R5 no busy before stop", int'(busy), 0);
      for (int i = 0; i < 3; i++) expect_wr(15'h0105 + 15'(i), 8'h10 + 8'(i));
      t_stop();
      wait_idle("R12 three bytes");

      // R4: wrap across offset 63 stays in row 0x2A00
      t_addr(15'h2A3E);
      for (int i = 0; i < 4; i++) t_byte(8'hC0 + 8'(i));
      expect_wr(15'h2A00, 8'hC2);
      expect_wr(15'h2A01, 8'hC3);
      expect_wr(15'h2A3E, 8'hC0);
      expect_wr(15'h2A3F, 8'hC1);
      t_stop();
      wait_idle("R4 wrap");

      // R4: 66 bytes overwrite offsets 0 and 1
      t_addr(15'h0400);
      for (int i = 0; i < 66; i++) t_byte(8'(i));
      for (int i = 0; i < 64; i++)
         expect_wr(15'h0400 + 15'(i), (i < 2) ? 8'(i + 64) : 8'(i));
      t_stop();
      wait_idle("R4 overwrite");

      // R9: write protect blocks and discards
      wp_in = 1'b1;
      t_addr(15'h0777);
      t_byte(8'h5A);
      t_stop();
      chk(busy == 1'b0, "R9 busy under wp", int'(busy), 0);
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R9 busy stays low", int'(busy), 0);
      wp_in = 1'b0;
      t_addr(15'h0010);
      t_byte(8'h3C);
      expect_wr(15'h0010, 8'h3C);
      t_stop();
      wait_idle("R9 discarded buffer");

      // R10: start before stop discards
      t_addr(15'h0200);
      t_byte(8'h11);
      t_byte(8'h22);
      t_start();
      t_stop();
      chk(busy == 1'b0, "R10 start discards", int'(busy), 0);
      t_addr(15'h0300);
      t_byte(8'h33);
      t_start();
      t_addr(15'h0320);
      t_byte(8'h44);
      expect_wr(15'h0320, 8'h44);
      t_stop();
      wait_idle("R10 only new bytes");

      // R11: stop after address only
      t_addr(15'h0600);
      t_stop();
      chk(busy == 1'b0, "R11 address only", int'(busy), 0);
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R11 stays idle", int'(busy), 0);

      // R8: strobes during busy are ignored
      t_addr(15'h0500);
      t_byte(8'h77);
      expect_wr(15'h0500, 8'h77);
      t_stop();
      t_addr(15'h0540);
      t_byte(8'h88);
      t_stop();
      t_start();
      wait_idle("R8 no extra writes");
      t_stop();
      chk(busy == 1'b0, "R8 buffer untouched", int'(busy), 0);
      repeat (5) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule